// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block runs complete SMBus host transactions from a small byte-wide register file. Software fills in the target address, the command code, a byte count and up to 32 payload bytes, then writes a protocol code to start. The sequencer turns that code into a series of byte-level bus steps and hands them one at a time to a lower bit-level engine, which owns SCL/SDA timing. The steps are start, repeated start, send a byte and sample the acknowledge, receive a byte and answer ACK or NACK, and stop.

Read results are written back into the payload registers. A received block length is written into the count register. The block can append a CRC-8 packet error code on writes and check it on reads. When the transaction ends, the status register shows a done flag and a 5-bit result code. Each bus step is issued as a one-cycle `bus_go` strobe. The step is finished when the engine pulses `bus_ack`.

Top module: `smb_xact_seq`

## Requirements
- R1: After reset, status (offset 0x01) reads 0x00, every register reads 0x00, and no bus step is issued.
- R2: Writing a supported code to the protocol register (offset 0x00) while idle starts a transaction. From the next cycle status reads 0x1A (done clear) until the end. While a transaction runs, host writes to any register are ignored: this covers a second protocol write and a write that falls in the same cycle as a received byte being stored. At the end, status bit 7 is set and bits 4:0 hold the result code.
- R3: A protocol code outside the supported set ends at once with status 0x99 (done plus code 0x19) and issues no bus step.
- R4: The step codes on `bus_op` are 0 start, 1 repeated start, 2 send, 3 receive-and-ACK, 4 receive-and-NACK, 5 stop. The first address byte is the address register (offset 0x02) bits 7:1 with bit 0 forced to the direction. A quick transaction (0x02 write, 0x03 read) is start, address, stop.
- R5: Writes send start, address with bit 0 = 0, the command (offset 0x03), then the payload, then stop. Byte data (0x06) sends one payload byte and word data (0x08) sends two, low byte first from payload offset 0x04, high byte from 0x05. Byte (0x04) sends the command as its only byte.
- R6: Reads (0x07, 0x09, and the other odd codes) send the command, then a repeated start and the address with bit 0 = 1, then receive. Every received byte but the last is ACKed. Results are stored from payload offset 0x04 upward, little-endian for words. Byte read (0x05) receives directly after the first address.
- R7: Block write (0x0A) sends the count (offset 0x24) capped at 32 before the payload. Block process call (0x0D) caps it at 31.
- R8: Block reads (0x0B, and the reply of 0x0D) take the first received byte as the length, store it capped at 32 into offset 0x24, and then receive that many bytes.
- R9: Raw block transfers (0x4A write, 0x4B read) send or receive the number of bytes preloaded in offset 0x24, capped at 32, with no count byte on the bus.
- R10: Process call (0x0C) sends two payload bytes and reads two back into the same offsets. Block process call sends a counted block and reads a counted block.
- R11: Protocol bit 7 adds a CRC-8 (polynomial 0x07, initial 0) over every address, command, count and data byte on the bus. On writes it is sent after the payload. On reads it is received last with NACK, and a mismatch ends with code 0x1F.
- R12: A NACK on any sent byte is followed directly by stop, and the transaction ends with status 0x90.
- R13: If the engine does not acknowledge a step within TMO_CYCLES cycles, the transaction ends with status 0x98 and no further step is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| bus_go | output | 1 | One-cycle strobe: engine takes `bus_op` and `bus_txd` |
| bus_op | output | 3 | Step code |
| bus_txd | output | 8 | Byte to send |
| bus_ack | input | 1 | Engine finished the current step |
| bus_rxd | input | 8 | Received byte, valid with `bus_ack` |
| bus_nak | input | 1 | Target did not acknowledge the sent byte, valid with `bus_ack` |

## Verification
A host write to a payload register can arrive in the same cycle that the sequencer stores a received byte at that offset. The bench provokes this by holding a write of 0xEE to offset 0x04 on every cycle of a word read, so one of those writes meets the store edge. The result is judged by reading back the received byte, not 0xEE, once the transaction ends. A second protocol write issued while busy is judged the same way, through the step count and the protocol register.

// File: rtl/smb_xact_seq.sv
module smb_xact_seq #(
  parameter int DATA_BYTES = 32,
  parameter int TMO_CYCLES = 300000
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              reg_wr,
  input  logic [$clog2(DATA_BYTES+8)-1:0]   reg_addr,
  input  logic [7:0]                        reg_wdata,
  output logic [7:0]                        reg_rdata,
  output logic                              bus_go,
  output logic [2:0]                        bus_op,
  output logic [7:0]                        bus_txd,
  input  logic                              bus_ack,
  input  logic [7:0]                        bus_rxd,
  input  logic                              bus_nak
);
  localparam int AW = $clog2(DATA_BYTES+8);
  localparam int XW = $clog2(DATA_BYTES);
  localparam int IW = XW + 1;
  localparam int TW = $clog2(TMO_CYCLES+1);
  localparam int CNT_OFF = 4 + DATA_BYTES;

  localparam logic [2:0] OP_START = 3'd0, OP_RSTART = 3'd1, OP_SEND = 3'd2,
                         OP_RACK = 3'd3, OP_RNAK = 3'd4, OP_STOP = 3'd5;

  typedef enum logic [3:0] {P_START, P_ADDR1, P_CMD, P_WCNT, P_WDATA, P_PECTX,
                            P_RSTART, P_ADDR2, P_RCNT, P_RDATA, P_PECRX, P_STOP} phase_t;
  typedef enum logic [3:0] {K_QUICK, K_BYTE, K_BDATA, K_WORD, K_BLOCK,
                            K_PROC, K_BPROC, K_I2C, K_BAD} kind_t;

  function automatic kind_t decode(input logic [6:0] p);
    case (p)
      7'h02, 7'h03: return K_QUICK;
      7'h04, 7'h05: return K_BYTE;
      7'h06, 7'h07: return K_BDATA;
      7'h08, 7'h09: return K_WORD;
      7'h0A, 7'h0B: return K_BLOCK;
      7'h0C:        return K_PROC;
      7'h0D:        return K_BPROC;
      7'h4A, 7'h4B: return K_I2C;
      default:      return K_BAD;
    endcase
  endfunction

  function automatic logic [IW-1:0] cap(input logic [7:0] v, input int m);
    return (int'(v) > m) ? IW'(m) : IW'(v);
  endfunction

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  logic [7:0] proto, tgt, cmd, cnt, crc;
  logic [7:0] data [DATA_BYTES];
  logic       done, running, issued, nakd, pecbad;
  logic [4:0] code;
  phase_t     ph, ph_n;
  logic [IW-1:0] idx, idx_n, left, left_n, wr_len, rd_len, rx_len;
  logic [TW-1:0] tmo;

  kind_t k;
  logic  rdbit, pec_on, rd_x, multi;
  phase_t aw, ar;

  assign k      = decode(proto[6:0]);
  assign rdbit  = proto[0];
  assign pec_on = proto[7] && k != K_QUICK && k != K_I2C;
  assign rd_x   = rdbit && (k == K_BDATA || k == K_WORD || k == K_BLOCK || k == K_I2C);
  assign multi  = (k == K_BLOCK || k == K_BPROC);
  assign aw     = (k == K_PROC || k == K_BPROC) ? P_RSTART : (pec_on ? P_PECTX : P_STOP);
  assign ar     = pec_on ? P_PECRX : P_STOP;
  assign rx_len = cap(bus_rxd, DATA_BYTES);

  always_comb begin
    case (k)
      K_BDATA:        wr_len = IW'(1);
      K_WORD, K_PROC: wr_len = IW'(2);
      K_BPROC:        wr_len = cap(cnt, DATA_BYTES-1);
      K_BLOCK, K_I2C: wr_len = cap(cnt, DATA_BYTES);
      default:        wr_len = '0;
    endcase
    case (k)
      K_BYTE, K_BDATA: rd_len = IW'(1);
      K_WORD, K_PROC:  rd_len = IW'(2);
      K_I2C:           rd_len = cap(cnt, DATA_BYTES);
      default:         rd_len = '0;
    endcase
  end

  assign bus_go = running && !issued;

  always_comb begin
    bus_op  = OP_SEND;
    bus_txd = 8'h00;
    case (ph)
      P_START:  bus_op = OP_START;
      P_RSTART: bus_op = OP_RSTART;
      P_STOP:   bus_op = OP_STOP;
      P_ADDR1:  bus_txd = {tgt[7:1], (k == K_QUICK || k == K_BYTE) && rdbit};
      P_CMD:    bus_txd = cmd;
      P_WCNT:   bus_txd = 8'(wr_len);
      P_WDATA:  bus_txd = data[idx[XW-1:0]];
      P_PECTX:  bus_txd = crc;
      P_ADDR2:  bus_txd = {tgt[7:1], 1'b1};
      P_RCNT:   bus_op = OP_RACK;
      P_RDATA:  bus_op = (left > IW'(1) || pec_on) ? OP_RACK : OP_RNAK;
      P_PECRX:  bus_op = OP_RNAK;
      default:  bus_op = OP_STOP;
    endcase
  end

  always_comb begin
    ph_n = ph; idx_n = idx; left_n = left;
    case (ph)
      P_START:  ph_n = P_ADDR1;
      P_ADDR1:
        if (k == K_QUICK) ph_n = P_STOP;
        else if (k == K_BYTE && rdbit) begin ph_n = P_RDATA; idx_n = '0; left_n = IW'(1); end
        else ph_n = P_CMD;
      P_CMD:
        if (k == K_BYTE) ph_n = pec_on ? P_PECTX : P_STOP;
        else if (rd_x) ph_n = P_RSTART;
        else if (multi) ph_n = P_WCNT;
        else begin idx_n = '0; left_n = wr_len; ph_n = (wr_len == '0) ? aw : P_WDATA; end
      P_WCNT: begin idx_n = '0; left_n = wr_len; ph_n = (wr_len == '0) ? aw : P_WDATA; end
      P_WDATA: begin
        idx_n = idx + 1'b1; left_n = left - 1'b1;
        if (left == IW'(1)) ph_n = aw;
      end
      P_PECTX:  ph_n = P_STOP;
      P_RSTART: ph_n = P_ADDR2;
      P_ADDR2: begin
        idx_n = '0;
        if (multi) ph_n = P_RCNT;
        else begin left_n = rd_len; ph_n = (rd_len == '0) ? ar : P_RDATA; end
      end
      P_RCNT: begin idx_n = '0; left_n = rx_len; ph_n = (rx_len == '0) ? ar : P_RDATA; end
      P_RDATA: begin
        idx_n = idx + 1'b1; left_n = left - 1'b1;
        if (left == IW'(1)) ph_n = ar;
      end
      P_PECRX:  ph_n = P_STOP;
      default:  ph_n = ph;
    endcase
  end

  logic in_data;
  assign in_data = reg_addr >= AW'(4) && reg_addr < AW'(CNT_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      proto <= '0; tgt <= '0; cmd <= '0; cnt <= '0; crc <= '0;
      for (int i = 0; i < DATA_BYTES; i++) data[i] <= '0;
      done <= 1'b0; code <= '0; running <= 1'b0; issued <= 1'b0;
      nakd <= 1'b0; pecbad <= 1'b0; ph <= P_START; idx <= '0; left <= '0; tmo <= '0;
    end else if (!running) begin
      if (reg_wr) begin
        if (reg_addr == AW'(0)) begin
          proto <= reg_wdata;
          if (decode(reg_wdata[6:0]) == K_BAD) begin
            done <= 1'b1; code <= 5'h19;
          end else begin
            done <= 1'b0; code <= 5'h1A; running <= 1'b1; issued <= 1'b0;
            ph <= P_START; crc <= '0; nakd <= 1'b0; pecbad <= 1'b0;
          end
        end
        if (reg_addr == AW'(2)) tgt <= reg_wdata;
        if (reg_addr == AW'(3)) cmd <= reg_wdata;
        if (reg_addr == AW'(CNT_OFF)) cnt <= reg_wdata;
        if (in_data) data[XW'(reg_addr - AW'(4))] <= reg_wdata;
      end
    end else if (!issued) begin
      issued <= 1'b1; tmo <= '0;
    end else if (bus_ack) begin
      issued <= 1'b0;
      if (bus_op == OP_SEND) crc <= crc8(crc, bus_txd);
      else if (ph == P_RCNT || ph == P_RDATA) crc <= crc8(crc, bus_rxd);
      if (ph == P_RDATA) data[idx[XW-1:0]] <= bus_rxd;
      if (ph == P_RCNT) cnt <= 8'(rx_len);
      if (ph == P_PECRX && bus_rxd != crc) pecbad <= 1'b1;
      if (ph == P_STOP) begin
        running <= 1'b0; done <= 1'b1;
        code <= nakd ? 5'h10 : (pecbad ? 5'h1F : 5'h00);
      end else if (bus_op == OP_SEND && bus_nak) begin
        nakd <= 1'b1; ph <= P_STOP;
      end else begin
        ph <= ph_n; idx <= idx_n; left <= left_n;
      end
    end else if (tmo == TW'(TMO_CYCLES-1)) begin
      running <= 1'b0; issued <= 1'b0; done <= 1'b1; code <= 5'h18;
    end else begin
      tmo <= tmo + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == AW'(0)) reg_rdata = proto;
    else if (reg_addr == AW'(1)) reg_rdata = {done, 2'b00, code};
    else if (reg_addr == AW'(2)) reg_rdata = tgt;
    else if (reg_addr == AW'(3)) reg_rdata = cmd;
    else if (in_data) reg_rdata = data[XW'(reg_addr - AW'(4))];
    else if (reg_addr == AW'(CNT_OFF)) reg_rdata = cnt;
  end
endmodule

// File: rtl/smb_xact_seq_chk.sv
module smb_xact_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          bus_go,
  input logic [2:0]    bus_op,
  input logic          bus_ack,
  input logic          bus_nak,
  input logic          done,
  input logic [4:0]    code,
  input logic          running
);
  a_r2_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == AW'(0) && !running) |=>
      (running ? (!done && code == 5'h1A) : (done && code == 5'h19)));

  a_r2_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (!done && code == 5'h1A));

  a_r2_end_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> (done && code != 5'h1A));

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    bus_go |=> !bus_go);

  a_r12_nak_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (running && bus_ack && !bus_go && bus_op == 3'd2 && bus_nak) |=>
      (bus_go && bus_op == 3'd5));
endmodule

bind smb_xact_seq smb_xact_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .bus_go(bus_go), .bus_op(bus_op), .bus_ack(bus_ack), .bus_nak(bus_nak),
  .done(done), .code(code), .running(running)
);

// File: tb/smb_xact_seq_test.sv
`timescale 1ns/1ps
module smb_xact_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic bus_go, bus_ack = 1'b0, bus_nak = 1'b0;
  logic [2:0] bus_op;
  logic [7:0] bus_txd, bus_rxd = '0;

  always #2.5 clk = ~clk;

  smb_xact_seq #(.DATA_BYTES(32), .TMO_CYCLES(200)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_go(bus_go),
    .bus_op(bus_op), .bus_txd(bus_txd), .bus_ack(bus_ack),
    .bus_rxd(bus_rxd), .bus_nak(bus_nak));

  int nchk = 0, nfail = 0;
  logic [2:0] lop [64];
  logic [7:0] ltx [64];
  logic [7:0] rxq [64];
  int nlog = 0, rxi = 0, nak_at = -1, wait_c = 0;
  bit hang = 0, pend = 0;
  logic [2:0] cur_op;

  always @(negedge clk) begin
    bus_ack = 1'b0; bus_nak = 1'b0;
    if (pend) begin
      if (wait_c == 0) begin
        bus_ack = 1'b1; pend = 0;
        if (cur_op == 3'd3 || cur_op == 3'd4) begin bus_rxd = rxq[rxi]; rxi++; end
        if (cur_op == 3'd2 && nak_at == nlog - 1) bus_nak = 1'b1;
      end else wait_c--;
    end else if (bus_go && rst_n) begin
      if (nlog < 64) begin lop[nlog] = bus_op; ltx[nlog] = bus_txd; end
      nlog++; cur_op = bus_op;
      if (!hang) begin pend = 1; wait_c = 1; end
    end
  end

  function automatic logic [7:0] pec(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x;
    x = c ^ b;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_done(output logic [7:0] s);
    for (int i = 0; i < 5000; i++) begin
      rd(6'h01, s);
      if (s[7]) break;
    end
  endtask

  task automatic clear();
    nlog = 0; rxi = 0; nak_at = -1; hang = 0;
    for (int i = 0; i < 64; i++) rxq[i] = 8'h02;
  endtask

  task automatic setup(input logic [7:0] c, input logic [7:0] d0, input logic [7:0] d1,
                       input logic [7:0] n);
    wr(6'h02, 8'hA6); wr(6'h03, c); wr(6'h04, d0); wr(6'h05, d1); wr(6'h24, n);
  endtask

  localparam logic [23:0] VEC [16] = '{
    24'h02_03_80, 24'h03_03_80, 24'h04_04_80, 24'h05_04_80,
    24'h06_05_80, 24'h07_07_80, 24'h08_06_80, 24'h09_08_80,
    24'h0A_08_80, 24'h0B_09_80, 24'h0C_0A_80, 24'h0D_0D_80,
    24'h4A_07_80, 24'h4B_09_80, 24'h0E_00_99, 24'h7F_00_99};

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] s, v, c;
    clear();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(6'h01, s); check("R1 status", s, 8'h00);
    rd(6'h24, v); check("R1 count", v, 8'h00);
    rd(6'h04, v); check("R1 data0", v, 8'h00);
    check("R1 no bus step", nlog, 0);

    // vector table: R3 R4 R5 R6 R8 R9 R10 step counts and status
    foreach (VEC[i]) begin
      clear();
      setup(8'h11, 8'h34, 8'h12, 8'h03);
      wr(6'h00, VEC[i][23:16]);
      wait_done(s);
      check(VEC[i][7:0] == 8'h99 ? "R3 status" : "R4 status", s, VEC[i][7:0]);
      check(VEC[i][7:0] == 8'h99 ? "R3 steps" : "R5 steps", nlog, VEC[i][15:8]);
    end

    // R5 word write byte order
    clear(); setup(8'h11, 8'h34, 8'h12, 8'h00);
    wr(6'h00, 8'h08); wait_done(s);
    check("R5 op0 start", lop[0], 0);
    check("R5 addr", ltx[1], 8'hA6);
    check("R5 cmd", ltx[2], 8'h11);
    check("R5 low", ltx[3], 8'h34);
    check("R5 high", ltx[4], 8'h12);
    check("R5 stop", lop[5], 5);

    // R6 word read
    clear(); setup(8'h11, 8'h00, 8'h00, 8'h00);
    rxq[0] = 8'hCD; rxq[1] = 8'hEF;
    wr(6'h00, 8'h09); wait_done(s);
    check("R6 rstart", lop[3], 1);
    check("R6 raddr", ltx[4], 8'hA7);
    check("R6 ack", lop[5], 3);
    check("R6 nack", lop[6], 4);
    rd(6'h04, v); check("R6 low", v, 8'hCD);
    rd(6'h05, v); check("R6 high", v, 8'hEF);

    // R7 caps
    clear(); setup(8'h11, 8'h00, 8'h00, 8'd40);
    wr(6'h00, 8'h0A); wait_done(s);
    check("R7 block count", ltx[3], 8'h20);
    check("R7 block steps", nlog, 37);
    clear(); setup(8'h11, 8'h00, 8'h00, 8'd40);
    rxq[0] = 8'h01; rxq[1] = 8'h77;
    wr(6'h00, 8'h0D); wait_done(s);
    check("R7 bproc count", ltx[3], 8'h1F);
    check("R10 bproc steps", nlog, 40);
    rd(6'h04, v); check("R10 bproc reply", v, 8'h77);
    rd(6'h24, v); check("R10 bproc reply count", v, 8'h01);

    // R8 block read capped
    clear(); setup(8'h11, 8'h00, 8'h00, 8'h00);
    rxq[0] = 8'd50;
    for (int i = 1; i < 64; i++) rxq[i] = 8'(i + 8'h40);
    wr(6'h00, 8'h0B); wait_done(s);
    rd(6'h24, v); check("R8 stored count", v, 8'h20);
    check("R8 steps", nlog, 39);
    rd(6'h23, v); check("R8 last byte", v, 8'h60);

    // R9 raw block read
    clear(); setup(8'h11, 8'h00, 8'h00, 8'h02);
    rxq[0] = 8'h91; rxq[1] = 8'h92;
    wr(6'h00, 8'h4B); wait_done(s);
    check("R9 no count byte", lop[5], 3);
    check("R9 steps", nlog, 8);
    rd(6'h04, v); check("R9 data0", v, 8'h91);
    rd(6'h05, v); check("R9 data1", v, 8'h92);
    rd(6'h24, v); check("R9 count kept", v, 8'h02);

    // R10 process call
    clear(); setup(8'h11, 8'h01, 8'h02, 8'h00);
    rxq[0] = 8'hAB; rxq[1] = 8'hCD;
    wr(6'h00, 8'h0C); wait_done(s);
    check("R10 sent low", ltx[3], 8'h01);
    check("R10 sent high", ltx[4], 8'h02);
    check("R10 rstart", lop[5], 1);
    rd(6'h04, v); check("R10 got low", v, 8'hAB);
    rd(6'h05, v); check("R10 got high", v, 8'hCD);

    // R11 PEC on write
    clear(); setup(8'h11, 8'h34, 8'h12, 8'h00);
    wr(6'h00, 8'h88); wait_done(s);
    c = pec(pec(pec(pec(8'h00, 8'hA6), 8'h11), 8'h34), 8'h12);
    check("R11 write steps", nlog, 7);
    check("R11 write pec", ltx[5], c);
    check("R11 write status", s, 8'h80);

    // R11 PEC on read, good then bad
    c = pec(pec(pec(pec(8'h00, 8'hA6), 8'h11), 8'hA7), 8'h5A);
    clear(); setup(8'h11, 8'h00, 8'h00, 8'h00);
    rxq[0] = 8'h5A; rxq[1] = c;
    wr(6'h00, 8'h87); wait_done(s);
    check("R11 read good", s, 8'h80);
    check("R11 data ack", lop[5], 3);
    check("R11 pec nack", lop[6], 4);
    clear(); rxq[0] = 8'h5A; rxq[1] = c ^ 8'h01;
    wr(6'h00, 8'h87); wait_done(s);
    check("R11 read bad", s, 8'h9F);

    // R12 NAK on address and on data
    clear(); setup(8'h11, 8'h34, 8'h12, 8'h00); nak_at = 1;
    wr(6'h00, 8'h08); wait_done(s);
    check("R12 addr nak status", s, 8'h90);
    check("R12 addr nak steps", nlog, 3);
    check("R12 stop after nak", lop[2], 5);
    clear(); nak_at = 3;
    wr(6'h00, 8'h08); wait_done(s);
    check("R12 data nak status", s, 8'h90);
    check("R12 data nak steps", nlog, 5);

    // R13 timeout
    clear(); hang = 1;
    wr(6'h00, 8'h04); wait_done(s);
    check("R13 status", s, 8'h98);
    repeat (10) @(negedge clk);
    check("R13 steps", nlog, 1);

    // R2 status during run and ignored protocol write
    clear(); setup(8'h11, 8'h34, 8'h12, 8'h00);
    wr(6'h00, 8'h08);
    rd(6'h01, s); check("R2 busy code", s, 8'h1A);
    wr(6'h00, 8'h02);
    wait_done(s);
    check("R2 second start ignored steps", nlog, 6);
    rd(6'h00, v); check("R2 protocol kept", v, 8'h08);

    // R2 host write colliding with received-byte store
    clear(); setup(8'h11, 8'h00, 8'h00, 8'h00);
    rxq[0] = 8'h44; rxq[1] = 8'h55;
    wr(6'h00, 8'h09);
    for (int i = 0; i < 400 && nlog < 8; i++) begin
      @(negedge clk); reg_wr = 1'b1; reg_addr = 6'h04; reg_wdata = 8'hEE;
    end
    @(negedge clk); reg_wr = 1'b0;
    wait_done(s);
    rd(6'h04, v); check("R2 store beats host write", v, 8'h44);
    rd(6'h05, v); check("R2 high byte", v, 8'h55);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule